// File: doc/BRIEF.md
# USB Host Attach Sequencer

This block is the attach controller for one downstream USB device behind a host-controller peripheral. It watches the peripheral's active-low interrupt line. Whenever the line is low and no service is running, it reads the host interrupt register and writes the same value back to clear the pending bits. It then acts on the event bits it saw. On a connect event it decodes the J/K line state, works out the device speed, programs the mode register and starts a bus reset. It turns the SOF keep-alive on while the bus reset runs and off again at the first frame event. At that point it moves to READY and pulses a start-enumeration output for the enumeration logic further on.

All peripheral access goes through a simple request/acknowledge register port. The port stands in for the serial link. Only one register operation is outstanding at a time. The block holds the request, with its address, direction and write data steady, until the peripheral acknowledges it. Each serviced interrupt takes at most one attach-state transition.

Top module: `usb_attach_seq`

## Requirements
- R1: While reset is asserted and just after it, the attach state is INIT (code 0), the register request is low and the start-enumeration pulse is low.
- R2: When the interrupt line is low and the block is idle, it reads the host interrupt register (address 25) and then writes exactly the value read back to address 25, which clears the pending bits.
- R3: A register request stays high, with address, direction and write data stable, until the cycle in which it is acknowledged. No other operation starts before that.
- R4: In INIT, a connect-detect event (interrupt bit 5) reads the line-state result register (address 31) and then the mode register (address 27). If exactly one of J (result bit 7) and K (result bit 6) is set, the block writes the mode register, then writes 0x01 (bus reset, bit 0) to the host control register (address 29), and enters CONNECTED (code 1).
- R5: The speed decision treats the device as low speed when J is set and mode bit 1 is set, or when K is set and mode bit 1 is clear. Low speed writes 0xC3 to address 27; full speed writes 0xC1.
- R6: In INIT, a connect event whose line state has both J and K clear, or both set, leaves the state in INIT and makes no mode or host-control write.
- R7: In CONNECTED, a bus event (interrupt bit 0) reads the mode register, writes it back with bit 3 (SOF keep-alive) set, and enters RESET (code 2).
- R8: In RESET, a frame event (bit 6) together with send-buffer-available (bit 3) reads the mode register and writes it back with bit 3 clear. The block then enters READY (code 3) with a single-cycle start-enumeration pulse. A frame event without send-buffer-available has no effect.
- R9: In CONNECTED, RESET or READY, a connect event that no earlier rule takes returns the block to INIT with no further register write.
- R10: The rules are tried in the order INIT-connect, CONNECTED-bus, RESET-frame, disconnect, and one service takes at most one transition. A bus event in CONNECTED beats a connect event in the same service, and so does a valid frame event in RESET.
- R11: Events that match no rule for the current state (for example a bus event in INIT or READY, or a frame event in READY) leave the state and the mode register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intN | input | 1 | Active-low interrupt line from the host-controller peripheral |
| regReq | output | 1 | Register operation request, held until acknowledged |
| regWrite | output | 1 | 1 = write, 0 = read |
| regAddr | output | ADDR_W (5) | Register address |
| regWdata | output | DATA_W (8) | Write data |
| regAck | input | 1 | Acknowledge; completes the current operation |
| regRdata | input | DATA_W (8) | Read data, valid in the acknowledge cycle |
| devState | output | 2 | Attach state: 0 INIT, 1 CONNECTED, 2 RESET, 3 READY |
| enumStart | output | 1 | Single-cycle pulse on entry to READY |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 8-bit data, the register addresses 25, 27, 29 and 31, and the stated bit positions. Every interrupt, line-state and mode combination in the rules can therefore be driven through a small peripheral model that clears interrupt bits on write-one. The model's acknowledge latency cycles through zero, one and two wait cycles, which exercises request holding across stalls. The vectors carry the mode register's low-speed bit both set and clear into the speed decision, so all four J/K-versus-mode outcomes are reached, along with the priority clashes between connect and the other events.

// File: rtl/usb_attach_seq_pkg.sv
package usb_attach_seq_pkg;

  typedef enum logic [1:0] {
    DEV_INIT      = 2'd0,
    DEV_CONNECTED = 2'd1,
    DEV_RESET     = 2'd2,
    DEV_READY     = 2'd3
  } devState_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RD_IRQ,
    OP_WR_IRQ,
    OP_DECIDE,
    OP_RD_LINE,
    OP_RD_MODE,
    OP_WR_MODE,
    OP_WR_BUSRST
  } op_e;

  typedef enum logic [1:0] {
    FL_SPEED,
    FL_SOF_ON,
    FL_SOF_OFF
  } flavor_e;

  typedef enum logic [1:0] {
    AS_IRQ,
    AS_LINE,
    AS_MODE,
    AS_CTRL
  } addrSel_e;

  typedef enum logic [2:0] {
    DS_ZERO,
    DS_IRQ,
    DS_SPEED,
    DS_SOF_ON,
    DS_SOF_OFF,
    DS_BUSRST
  } dataSel_e;

  typedef struct packed {
    logic     capIrq;
    logic     capLine;
    logic     capMode;
    addrSel_e addrSel;
    dataSel_e dataSel;
  } strobe_t;

endpackage

// File: rtl/usb_attach_seq_dp.sv
module usb_attach_seq_dp
  import usb_attach_seq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int IRQ_ADDR   = 25,
  parameter int MODE_ADDR  = 27,
  parameter int CTRL_ADDR  = 29,
  parameter int LINE_ADDR  = 31,
  parameter int BUS_BIT    = 0,
  parameter int SNDBAV_BIT = 3,
  parameter int CONN_BIT   = 5,
  parameter int FRAME_BIT  = 6,
  parameter int J_BIT      = 7,
  parameter int K_BIT      = 6,
  parameter int LOWSPD_BIT = 1,
  parameter int SOFKA_BIT  = 3,
  parameter int BUSRST_BIT = 0,
  parameter int MODE_LOW   = 'hC3,
  parameter int MODE_FULL  = 'hC1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              evBus,
  output logic              evSndBav,
  output logic              evConn,
  output logic              evFrame,
  output logic              jkValid
);

  localparam logic [DATA_W-1:0] SOF_MASK    = DATA_W'(1) << SOFKA_BIT;
  localparam logic [DATA_W-1:0] BUSRST_WORD = DATA_W'(1) << BUSRST_BIT;
  localparam logic [DATA_W-1:0] LOW_WORD    = DATA_W'(MODE_LOW);
  localparam logic [DATA_W-1:0] FULL_WORD   = DATA_W'(MODE_FULL);

  logic [DATA_W-1:0] irqQ;
  logic [DATA_W-1:0] modeQ;
  logic              lineJ;
  logic              lineK;
  logic              lowSpeed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ  <= '0;
      modeQ <= '0;
      lineJ <= 1'b0;
      lineK <= 1'b0;
    end else begin
      if (strobe.capIrq) irqQ <= regRdata;
      if (strobe.capMode) modeQ <= regRdata;
      if (strobe.capLine) begin
        lineJ <= regRdata[J_BIT];
        lineK <= regRdata[K_BIT];
      end
    end
  end

  always_comb begin
    evBus    = irqQ[BUS_BIT];
    evSndBav = irqQ[SNDBAV_BIT];
    evConn   = irqQ[CONN_BIT];
    evFrame  = irqQ[FRAME_BIT];
    jkValid  = lineJ ^ lineK;
    lowSpeed = (lineJ & modeQ[LOWSPD_BIT]) | (lineK & ~modeQ[LOWSPD_BIT]);
  end

  always_comb begin
    unique case (strobe.addrSel)
      AS_IRQ:  regAddr = ADDR_W'(IRQ_ADDR);
      AS_LINE: regAddr = ADDR_W'(LINE_ADDR);
      AS_MODE: regAddr = ADDR_W'(MODE_ADDR);
      default: regAddr = ADDR_W'(CTRL_ADDR);
    endcase
  end

  always_comb begin
    case (strobe.dataSel)
      DS_IRQ:     regWdata = irqQ;
      DS_SPEED:   regWdata = lowSpeed ? LOW_WORD : FULL_WORD;
      DS_SOF_ON:  regWdata = modeQ | SOF_MASK;
      DS_SOF_OFF: regWdata = modeQ & ~SOF_MASK;
      DS_BUSRST:  regWdata = BUSRST_WORD;
      default:    regWdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_attach_seq_ctrl.sv
module usb_attach_seq_ctrl
  import usb_attach_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intN,
  input  logic       regAck,
  input  logic       evBus,
  input  logic       evSndBav,
  input  logic       evConn,
  input  logic       evFrame,
  input  logic       jkValid,
  output logic       regReq,
  output logic       regWrite,
  output strobe_t    strobe,
  output logic [1:0] devState,
  output logic       enumStart
);

  op_e       opQ;
  flavor_e   flavorQ;
  devState_e stateQ;
  logic      done;

  assign devState = stateQ;

  always_comb begin
    regReq   = (opQ != OP_IDLE) && (opQ != OP_DECIDE);
    regWrite = (opQ == OP_WR_IRQ) || (opQ == OP_WR_MODE) || (opQ == OP_WR_BUSRST);
    done     = regReq && regAck;

    strobe.capIrq  = done && (opQ == OP_RD_IRQ);
    strobe.capLine = done && (opQ == OP_RD_LINE);
    strobe.capMode = done && (opQ == OP_RD_MODE);

    case (opQ)
      OP_RD_LINE:              strobe.addrSel = AS_LINE;
      OP_RD_MODE, OP_WR_MODE:  strobe.addrSel = AS_MODE;
      OP_WR_BUSRST:            strobe.addrSel = AS_CTRL;
      default:                 strobe.addrSel = AS_IRQ;
    endcase

    case (opQ)
      OP_WR_IRQ:    strobe.dataSel = DS_IRQ;
      OP_WR_BUSRST: strobe.dataSel = DS_BUSRST;
      OP_WR_MODE: begin
        case (flavorQ)
          FL_SOF_ON:  strobe.dataSel = DS_SOF_ON;
          FL_SOF_OFF: strobe.dataSel = DS_SOF_OFF;
          default:    strobe.dataSel = DS_SPEED;
        endcase
      end
      default:      strobe.dataSel = DS_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ       <= OP_IDLE;
      flavorQ   <= FL_SPEED;
      stateQ    <= DEV_INIT;
      enumStart <= 1'b0;
    end else begin
      enumStart <= 1'b0;
      case (opQ)
        OP_IDLE: begin
          if (!intN) opQ <= OP_RD_IRQ;
        end
        OP_RD_IRQ: begin
          if (done) opQ <= OP_WR_IRQ;
        end
        OP_WR_IRQ: begin
          if (done) opQ <= OP_DECIDE;
        end
        OP_DECIDE: begin
          if (stateQ == DEV_INIT && evConn) begin
            flavorQ <= FL_SPEED;
            opQ     <= OP_RD_LINE;
          end else if (stateQ == DEV_CONNECTED && evBus) begin
            flavorQ <= FL_SOF_ON;
            opQ     <= OP_RD_MODE;
          end else if (stateQ == DEV_RESET && evFrame && evSndBav) begin
            flavorQ <= FL_SOF_OFF;
            opQ     <= OP_RD_MODE;
          end else if (stateQ != DEV_INIT && evConn) begin
            stateQ <= DEV_INIT;
            opQ    <= OP_IDLE;
          end else begin
            opQ <= OP_IDLE;
          end
        end
        OP_RD_LINE: begin
          if (done) opQ <= OP_RD_MODE;
        end
        OP_RD_MODE: begin
          if (done) begin
            if (flavorQ == FL_SPEED && !jkValid) opQ <= OP_IDLE;
            else opQ <= OP_WR_MODE;
          end
        end
        OP_WR_MODE: begin
          if (done) begin
            case (flavorQ)
              FL_SOF_ON: begin
                stateQ <= DEV_RESET;
                opQ    <= OP_IDLE;
              end
              FL_SOF_OFF: begin
                stateQ    <= DEV_READY;
                enumStart <= 1'b1;
                opQ       <= OP_IDLE;
              end
              default: opQ <= OP_WR_BUSRST;
            endcase
          end
        end
        OP_WR_BUSRST: begin
          if (done) begin
            stateQ <= DEV_CONNECTED;
            opQ    <= OP_IDLE;
          end
        end
        default: opQ <= OP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/usb_attach_seq.sv
module usb_attach_seq
  import usb_attach_seq_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int IRQ_ADDR   = 25,
  parameter int MODE_ADDR  = 27,
  parameter int CTRL_ADDR  = 29,
  parameter int LINE_ADDR  = 31,
  parameter int BUS_BIT    = 0,
  parameter int SNDBAV_BIT = 3,
  parameter int CONN_BIT   = 5,
  parameter int FRAME_BIT  = 6,
  parameter int J_BIT      = 7,
  parameter int K_BIT      = 6,
  parameter int LOWSPD_BIT = 1,
  parameter int SOFKA_BIT  = 3,
  parameter int BUSRST_BIT = 0,
  parameter int MODE_LOW   = 'hC3,
  parameter int MODE_FULL  = 'hC1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              intN,
  output logic              regReq,
  output logic              regWrite,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRdata,
  output logic [1:0]        devState,
  output logic              enumStart
);

  strobe_t strobe;
  logic    evBus;
  logic    evSndBav;
  logic    evConn;
  logic    evFrame;
  logic    jkValid;

  usb_attach_seq_ctrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .intN     (intN),
    .regAck   (regAck),
    .evBus    (evBus),
    .evSndBav (evSndBav),
    .evConn   (evConn),
    .evFrame  (evFrame),
    .jkValid  (jkValid),
    .regReq   (regReq),
    .regWrite (regWrite),
    .strobe   (strobe),
    .devState (devState),
    .enumStart(enumStart)
  );

  usb_attach_seq_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IRQ_ADDR  (IRQ_ADDR),
    .MODE_ADDR (MODE_ADDR),
    .CTRL_ADDR (CTRL_ADDR),
    .LINE_ADDR (LINE_ADDR),
    .BUS_BIT   (BUS_BIT),
    .SNDBAV_BIT(SNDBAV_BIT),
    .CONN_BIT  (CONN_BIT),
    .FRAME_BIT (FRAME_BIT),
    .J_BIT     (J_BIT),
    .K_BIT     (K_BIT),
    .LOWSPD_BIT(LOWSPD_BIT),
    .SOFKA_BIT (SOFKA_BIT),
    .BUSRST_BIT(BUSRST_BIT),
    .MODE_LOW  (MODE_LOW),
    .MODE_FULL (MODE_FULL)
  ) dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regRdata(regRdata),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .evBus   (evBus),
    .evSndBav(evSndBav),
    .evConn  (evConn),
    .evFrame (evFrame),
    .jkValid (jkValid)
  );

endmodule

// File: rtl/usb_attach_seq_chk.sv
module usb_attach_seq_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regReq,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regAck,
  input logic [1:0]        devState,
  input logic              enumStart
);

  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata)));

  assert_enum_in_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    enumStart |-> (devState == 2'd3));

  assert_enum_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    enumStart |=> !enumStart);

  assert_ready_entry_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((devState == 2'd3) && ($past(devState) == 2'd2)) |-> enumStart);

  assert_init_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (($past(devState) == 2'd0) && (devState != 2'd0)) |-> (devState == 2'd1));

  assert_reset_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (($past(devState) != 2'd2) && (devState == 2'd2)) |-> ($past(devState) == 2'd1));

endmodule

bind usb_attach_seq usb_attach_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .regReq   (regReq),
  .regWrite (regWrite),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .regAck   (regAck),
  .devState (devState),
  .enumStart(enumStart)
);

// File: tb/usb_attach_seq_test.sv
`timescale 1ns/1ps
module usb_attach_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intN;
  logic       regReq;
  logic       regWrite;
  logic [4:0] regAddr;
  logic [7:0] regWdata;
  logic       regAck;
  logic [7:0] regRdata;
  logic [1:0] devState;
  logic       enumStart;

  always #2 clk = ~clk;

  usb_attach_seq uut (
    .clk(clk), .rstN(rstN), .intN(intN),
    .regReq(regReq), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck), .regRdata(regRdata),
    .devState(devState), .enumStart(enumStart)
  );

  // peripheral model
  logic [7:0] regs [32];
  logic       ackR;
  logic [7:0] rdataR;
  int         waitCnt;
  int         lat = 0;
  logic       injGo = 1'b0;
  logic [7:0] injIrq = '0;
  logic [7:0] injLine = '0;
  logic [7:0] lastIrqRd, lastIrqWr;
  int         modeWrites, rstWrites, enumCnt, enumWide, protoErr;

  assign regAck   = ackR;
  assign regRdata = rdataR;
  assign intN     = (regs[25] == 8'h00);

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) regs[i] <= 8'h00;
      ackR <= 1'b0; rdataR <= 8'h00; waitCnt <= 0;
      lastIrqRd <= 8'h00; lastIrqWr <= 8'h00;
      modeWrites <= 0; rstWrites <= 0;
    end else begin
      if (injGo) begin
        regs[25] <= injIrq;
        regs[31] <= injLine;
      end
      if (ackR) ackR <= 1'b0;
      else if (regReq) begin
        if (waitCnt < lat) waitCnt <= waitCnt + 1;
        else begin
          waitCnt <= 0;
          ackR <= 1'b1;
          if (regWrite) begin
            if (regAddr == 5'd25) begin
              regs[25]  <= regs[25] & ~regWdata;
              lastIrqWr <= regWdata;
            end else begin
              regs[regAddr] <= regWdata;
              if (regAddr == 5'd27) modeWrites <= modeWrites + 1;
              if (regAddr == 5'd29 && regWdata == 8'h01) rstWrites <= rstWrites + 1;
            end
          end else begin
            rdataR <= regs[regAddr];
            if (regAddr == 5'd25) lastIrqRd <= regs[25];
          end
        end
      end
    end
  end

  logic       pReq, pAck, pW, pEnum;
  logic [4:0] pAddr;
  logic [7:0] pData;
  initial begin enumCnt = 0; enumWide = 0; protoErr = 0; end
  always @(posedge clk) begin
    if (rstN) begin
      if (pReq && !pAck && (!regReq || regAddr != pAddr || regWrite != pW || regWdata != pData))
        protoErr <= protoErr + 1;
      if (enumStart) enumCnt <= enumCnt + 1;
      if (enumStart && pEnum) enumWide <= enumWide + 1;
    end
    pReq <= rstN && regReq; pAck <= regAck; pW <= regWrite;
    pAddr <= regAddr; pData <= regWdata; pEnum <= rstN && enumStart;
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // {irq, line, expState, expMode, expEnum, expRst, expModeWrites}
  localparam int NV = 18;
  localparam logic [37:0] VEC [NV] = '{
    {8'h20, 8'h40, 2'd1, 8'hC3, 4'd0, 4'd1, 4'd1},
    {8'h21, 8'h00, 2'd2, 8'hCB, 4'd0, 4'd1, 4'd2},
    {8'h40, 8'h00, 2'd2, 8'hCB, 4'd0, 4'd1, 4'd2},
    {8'h60, 8'h00, 2'd0, 8'hCB, 4'd0, 4'd1, 4'd2},
    {8'h20, 8'h80, 2'd1, 8'hC3, 4'd0, 4'd2, 4'd3},
    {8'h20, 8'h00, 2'd0, 8'hC3, 4'd0, 4'd2, 4'd3},
    {8'h20, 8'hC0, 2'd0, 8'hC3, 4'd0, 4'd2, 4'd3},
    {8'h20, 8'h00, 2'd0, 8'hC3, 4'd0, 4'd2, 4'd3},
    {8'h20, 8'h40, 2'd1, 8'hC1, 4'd0, 4'd3, 4'd4},
    {8'h01, 8'h00, 2'd2, 8'hC9, 4'd0, 4'd3, 4'd5},
    {8'h48, 8'h00, 2'd3, 8'hC1, 4'd1, 4'd3, 4'd6},
    {8'h01, 8'h00, 2'd3, 8'hC1, 4'd1, 4'd3, 4'd6},
    {8'h48, 8'h00, 2'd3, 8'hC1, 4'd1, 4'd3, 4'd6},
    {8'h20, 8'h00, 2'd0, 8'hC1, 4'd1, 4'd3, 4'd6},
    {8'h01, 8'h00, 2'd0, 8'hC1, 4'd1, 4'd3, 4'd6},
    {8'h20, 8'h80, 2'd1, 8'hC1, 4'd1, 4'd4, 4'd7},
    {8'h09, 8'h00, 2'd2, 8'hC9, 4'd1, 4'd4, 4'd8},
    {8'h68, 8'h00, 2'd3, 8'hC1, 4'd2, 4'd4, 4'd9}
  };

  function automatic string tagOf(int i);
    case (i)
      0:       return "R4 R5";
      1:       return "R7 R10";
      2:       return "R8";
      3:       return "R9 R10";
      4:       return "R4 R5";
      5:       return "R9";
      6, 7:    return "R6";
      8:       return "R5";
      9:       return "R7";
      10:      return "R8";
      11, 12:  return "R11";
      13:      return "R9";
      14:      return "R11";
      15:      return "R4 R5";
      16:      return "R10";
      default: return "R8 R10";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(devState == 2'd0 && !regReq && !enumStart, "R1", "state in reset", devState, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(devState == 2'd0 && !regReq && !enumStart, "R1", "state after reset", devState, 0);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      string t;
      int guard;
      v = VEC[i];
      t = tagOf(i);
      lat = i % 3;
      @(negedge clk);
      injIrq = v[37:30]; injLine = v[29:22]; injGo = 1'b1;
      @(negedge clk) injGo = 1'b0;
      guard = 0;
      while (!intN && guard < 300) begin @(negedge clk); guard++; end
      repeat (60) @(negedge clk);
      check(intN && lastIrqRd == v[37:30] && lastIrqWr == v[37:30], "R2", "irq read/ack", lastIrqWr, v[37:30]);
      check(devState == v[21:20], t, "state", devState, v[21:20]);
      check(regs[27] == v[19:12], t, "mode", regs[27], v[19:12]);
      check(enumCnt == v[11:8], t, "enum pulses", enumCnt, v[11:8]);
      check(rstWrites == v[7:4], t, "bus resets", rstWrites, v[7:4]);
      check(modeWrites == v[3:0], t, "mode writes", modeWrites, v[3:0]);
    end

    check(protoErr == 0, "R3", "request held until ack", protoErr, 0);
    check(enumWide == 0, "R8", "enum pulse width", enumWide, 0);

    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    check(devState == 2'd0 && !regReq && !enumStart, "R1", "state in mid reset", devState, 0);
    @(negedge clk) rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(devState == 2'd0 && !regReq, "R1", "state after mid reset", devState, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule